// File: doc/BRIEF.md
# I2C Slave Address Match and Acknowledge

This block is the receiving front end of a two-wire serial controller working as a slave. It synchronizes the clock and data lines, finds start and stop conditions, and shifts in the first byte after a start. That byte holds a 7-bit address and a direction bit. The block compares the byte with a programmable own address and with the all-zero general-call byte. When either one matches, it pulls the data line low for the acknowledge clock.

On the falling edge of the acknowledge clock it raises a one-cycle interrupt, clears its pending flag and copies the direction bit into its transmit flag. It then holds the clock line low until the host writes the pending flag back to 1. When the address does not match, it leaves both lines released and ignores the bus until the next start.

Both bus outputs are pull-down enables for open-drain pads. A 1 means drive the line low.

Top module: `i2c_addr_slave`

## Requirements
- R1: After reset, pend is 1, trx is 0, busy is 0, addr_hit and gcall_hit are 0, and neither sda_pull nor scl_pull is asserted.
- R2: SDA falling while SCL is high is a start and sets busy. SDA rising while SCL is high is a stop, which clears busy and returns the block to idle.
- R3: After a start, the block samples SDA on each of 8 SCL rising edges, most significant bit first. The first 7 bits form the address and the 8th (bit 0 of the byte) is the direction bit.
- R4: With addr_fmt 0, a byte whose upper 7 bits equal own_addr is acknowledged. sda_pull is asserted from the 8th SCL falling edge until the 9th falling edge, and addr_hit is set.
- R5: The byte 0x00 is a general call. It is acknowledged, sets gcall_hit and leaves addr_hit at 0.
- R6: On the 9th SCL falling edge of an acknowledged byte, irq pulses for exactly one clock and pend goes to 0.
- R7: scl_pull is asserted while pend is 0. A one-cycle pend_set pulse sets pend to 1 and releases SCL.
- R8: After an acknowledged byte, trx takes the received direction bit. After a byte that is not acknowledged, trx keeps its previous value.
- R9: When the byte does not match, the block asserts neither pull output and raises no irq, also for further SCL pulses before the next start.
- R10: With addr_fmt 1, no byte is acknowledged, not even a general call.
- R11: A start that arrives part way through the address byte restarts the bit count. The byte is then taken from the 8 bits that follow the new start.
- R12: Every start clears addr_hit and gcall_hit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | SCL line level from the pad, asynchronous |
| sda_i | input | 1 | SDA line level from the pad, asynchronous |
| own_addr_i | input | 7 | Programmed own slave address |
| addr_fmt_i | input | 1 | Address format select; 0 = addressed operation |
| pend_set_i | input | 1 | Host write pulse setting pend back to 1 |
| sda_pull_o | output | 1 | Pull SDA low (acknowledge) |
| scl_pull_o | output | 1 | Pull SCL low (clock stretch) |
| irq_o | output | 1 | One-cycle interrupt request |
| addr_hit_o | output | 1 | Own address was acknowledged |
| gcall_hit_o | output | 1 | General call was acknowledged |
| trx_o | output | 1 | Transmit flag taken from the direction bit |
| busy_o | output | 1 | Bus busy between start and stop |
| pend_o | output | 1 | Pending flag; 0 while waiting for host service |

## Verification
Each bus event reaches the outputs three clock edges after the pin changes. Two of those edges are synchronizer stages and the third is the state register, so sda_pull, irq, pend, trx, the hit bits and busy all change on that third edge. scl_pull follows pend in the same cycle, and pend rises one edge after a pend_set pulse. The bench holds every SCL and SDA phase for eight clocks and samples at the falling clock edge at the end of the phase, which is well past the due cycle. The one-cycle irq pulse is counted by a monitor, and the bench compares the change in that count across each acknowledge clock.

// File: rtl/i2c_as_pkg.sv
package i2c_as_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ACK,
        ST_HOLD,
        ST_SKIP
    } as_state_e;

    typedef struct packed {
        logic start;
        logic stop;
        logic rise;
        logic fall;
        logic sda;
    } bus_evt_t;

endpackage

// File: rtl/i2c_as_sync.sv
module i2c_as_sync #(
    parameter int LINES  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [LINES-1:0] d_i,
    output logic [LINES-1:0] q_o
);
    localparam int CHAIN_W = LINES * STAGES;

    logic [CHAIN_W-1:0] chain_d, chain_q;

    generate
        if (STAGES == 1) begin : g_single
            always_comb chain_d = d_i;
        end else begin : g_multi
            always_comb chain_d = {chain_q[CHAIN_W-LINES-1:0], d_i};
        end
    endgenerate

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain_q <= '1;
        else         chain_q <= chain_d;
    end

    assign q_o = chain_q[CHAIN_W-1 -: LINES];

endmodule

// File: rtl/i2c_as_cond.sv
module i2c_as_cond
    import i2c_as_pkg::*;
(
    input  logic     clk_i,
    input  logic     rst_ni,
    input  logic     scl_s_i,
    input  logic     sda_s_i,
    output bus_evt_t evt_o
);
    typedef struct packed {
        logic scl;
        logic sda;
    } prev_t;

    prev_t prev_d, prev_q;

    always_comb begin
        prev_d.scl = scl_s_i;
        prev_d.sda = sda_s_i;
        evt_o.start = scl_s_i & prev_q.scl & prev_q.sda & ~sda_s_i;
        evt_o.stop  = scl_s_i & prev_q.scl & ~prev_q.sda & sda_s_i;
        evt_o.rise  = scl_s_i & ~prev_q.scl;
        evt_o.fall  = ~scl_s_i & prev_q.scl;
        evt_o.sda   = sda_s_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) prev_q <= '1;
        else         prev_q <= prev_d;
    end

    // R2
    start_stop_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(evt_o.start && evt_o.stop));

endmodule

// File: rtl/i2c_as_fsm.sv
module i2c_as_fsm
    import i2c_as_pkg::*;
#(
    parameter int ADDR_W = 7
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  bus_evt_t          evt_i,
    input  logic [ADDR_W-1:0] own_addr_i,
    input  logic              addr_fmt_i,
    input  logic              pend_set_i,
    output logic              sda_pull_o,
    output logic              scl_pull_o,
    output logic              irq_o,
    output logic              addr_hit_o,
    output logic              gcall_hit_o,
    output logic              trx_o,
    output logic              busy_o,
    output logic              pend_o
);
    localparam int BITS = ADDR_W + 1;
    localparam int CW   = $clog2(BITS + 1);
    localparam logic [CW-1:0] LAST = CW'(BITS);

    typedef struct packed {
        as_state_e       st;
        logic [CW-1:0]   cnt;
        logic [BITS-1:0] shreg;
        logic            addr_hit;
        logic            gcall_hit;
        logic            trx;
        logic            busy;
        logic            pend;
        logic            irq;
        logic            sda_pull;
    } fsm_t;

    fsm_t s_d, s_q;
    logic is_gc, is_own, do_ack;

    always_comb begin
        is_gc  = (s_q.shreg == '0);
        is_own = (s_q.shreg[BITS-1:1] == own_addr_i);
        do_ack = !addr_fmt_i && (is_gc || is_own);

        s_d     = s_q;
        s_d.irq = 1'b0;
        if (pend_set_i) s_d.pend = 1'b1;

        if (evt_i.stop) begin
            s_d.st       = ST_IDLE;
            s_d.busy     = 1'b0;
            s_d.sda_pull = 1'b0;
        end else if (evt_i.start) begin
            s_d.st        = ST_ADDR;
            s_d.cnt       = '0;
            s_d.busy      = 1'b1;
            s_d.addr_hit  = 1'b0;
            s_d.gcall_hit = 1'b0;
            s_d.sda_pull  = 1'b0;
        end else begin
            unique case (s_q.st)
                ST_ADDR: begin
                    if (evt_i.rise && s_q.cnt < LAST) begin
                        s_d.shreg = {s_q.shreg[BITS-2:0], evt_i.sda};
                        s_d.cnt   = s_q.cnt + 1'b1;
                    end else if (evt_i.fall && s_q.cnt == LAST) begin
                        if (do_ack) begin
                            s_d.st        = ST_ACK;
                            s_d.sda_pull  = 1'b1;
                            s_d.gcall_hit = is_gc;
                            s_d.addr_hit  = !is_gc;
                        end else begin
                            s_d.st = ST_SKIP;
                        end
                    end
                end
                ST_ACK: begin
                    if (evt_i.fall) begin
                        s_d.sda_pull = 1'b0;
                        s_d.irq      = 1'b1;
                        s_d.pend     = 1'b0;
                        s_d.trx      = s_q.shreg[0];
                        s_d.st       = ST_HOLD;
                    end
                end
                ST_HOLD: begin
                    if (pend_set_i) s_d.st = ST_SKIP;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            s_q      <= '0;
            s_q.st   <= ST_IDLE;
            s_q.pend <= 1'b1;
        end else begin
            s_q <= s_d;
        end
    end

    assign sda_pull_o  = s_q.sda_pull;
    assign scl_pull_o  = !s_q.pend;
    assign irq_o       = s_q.irq;
    assign addr_hit_o  = s_q.addr_hit;
    assign gcall_hit_o = s_q.gcall_hit;
    assign trx_o       = s_q.trx;
    assign busy_o      = s_q.busy;
    assign pend_o      = s_q.pend;

    // R2
    start_sets_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        evt_i.start |=> busy_o);

    // R4
    ack_needs_hit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        sda_pull_o |-> (addr_hit_o || gcall_hit_o));

    // R5
    gcall_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(gcall_hit_o && addr_hit_o));

    // R6
    irq_after_ack_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(irq_o) |-> $past(sda_pull_o));

    // R7
    pend_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (scl_pull_o && pend_set_i) |=> !scl_pull_o);

    // R10
    fmt_blocks_ack_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (addr_fmt_i && !sda_pull_o && !evt_i.stop) |=> !sda_pull_o);

endmodule

// File: rtl/i2c_addr_slave.sv
module i2c_addr_slave
    import i2c_as_pkg::*;
#(
    parameter int ADDR_W      = 7,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              scl_i,
    input  logic              sda_i,
    input  logic [ADDR_W-1:0] own_addr_i,
    input  logic              addr_fmt_i,
    input  logic              pend_set_i,
    output logic              sda_pull_o,
    output logic              scl_pull_o,
    output logic              irq_o,
    output logic              addr_hit_o,
    output logic              gcall_hit_o,
    output logic              trx_o,
    output logic              busy_o,
    output logic              pend_o
);
    logic [1:0] line_s;
    bus_evt_t   evt;

    i2c_as_sync #(.LINES(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .d_i    ({scl_i, sda_i}),
        .q_o    (line_s)
    );

    i2c_as_cond u_cond (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .scl_s_i (line_s[1]),
        .sda_s_i (line_s[0]),
        .evt_o   (evt)
    );

    i2c_as_fsm #(.ADDR_W(ADDR_W)) u_fsm (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .evt_i       (evt),
        .own_addr_i  (own_addr_i),
        .addr_fmt_i  (addr_fmt_i),
        .pend_set_i  (pend_set_i),
        .sda_pull_o  (sda_pull_o),
        .scl_pull_o  (scl_pull_o),
        .irq_o       (irq_o),
        .addr_hit_o  (addr_hit_o),
        .gcall_hit_o (gcall_hit_o),
        .trx_o       (trx_o),
        .busy_o      (busy_o),
        .pend_o      (pend_o)
    );

endmodule

// File: tb/i2c_addr_slave_tb.sv
`timescale 1ns/1ps
module i2c_addr_slave_tb;
    localparam int W = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_drv = 1'b1, sda_drv = 1'b1;
    logic [6:0] own = 7'h5A;
    logic fmt = 1'b0;
    logic pend_set = 1'b0;
    logic sda_pull, scl_pull, irq, addr_hit, gcall_hit, trx, busy, pend;
    logic scl_line, sda_line;
    int checks = 0, errors = 0, irq_cnt = 0;
    logic exp_trx = 1'b0;
    logic done = 1'b0;

    always #2 clk = ~clk;

    assign scl_line = scl_drv & ~scl_pull;
    assign sda_line = sda_drv & ~sda_pull;

    i2c_addr_slave u_dut (
        .clk_i(clk), .rst_ni(rst_n), .scl_i(scl_line), .sda_i(sda_line),
        .own_addr_i(own), .addr_fmt_i(fmt), .pend_set_i(pend_set),
        .sda_pull_o(sda_pull), .scl_pull_o(scl_pull), .irq_o(irq),
        .addr_hit_o(addr_hit), .gcall_hit_o(gcall_hit), .trx_o(trx),
        .busy_o(busy), .pend_o(pend)
    );

    always @(posedge clk) if (irq) irq_cnt <= irq_cnt + 1;

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic wt(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [1:0] exp_hit(input logic [7:0] b, input logic [6:0] o,
                                           input logic f);
        logic gc;
        gc = (b == 8'h00);
        if (f) return 2'b00;
        return {gc, (b[7:1] == o) && !gc};
    endfunction

    task automatic start_c();
        sda_drv = 1'b1; wt(W);
        scl_drv = 1'b1; wt(W);
        sda_drv = 1'b0; wt(W);
        scl_drv = 1'b0; wt(W);
    endtask

    task automatic stop_c();
        sda_drv = 1'b0; wt(W);
        scl_drv = 1'b1; wt(W);
        sda_drv = 1'b1; wt(W);
    endtask

    task automatic clk_bit(input logic b);
        sda_drv = b;    wt(W);
        scl_drv = 1'b1; wt(W);
        scl_drv = 1'b0; wt(W);
    endtask

    task automatic bits8(input logic [7:0] b);
        for (int i = 7; i >= 0; i--) clk_bit(b[i]);
        sda_drv = 1'b1;
    endtask

    task automatic xact(input logic [7:0] b, input string tag);
        logic [1:0] e;
        logic ack;
        int irq0;
        e = exp_hit(b, own, fmt);
        ack = |e;
        start_c();
        chk("R2 busy after start", busy, 1);
        chk("R12 hits cleared at start", {gcall_hit, addr_hit}, 0);
        irq0 = irq_cnt;
        bits8(b);
        wt(W);
        chk({tag, " ack pull after 8th fall"}, sda_pull, ack);
        chk("R4 addr_hit", addr_hit, e[0]);
        chk("R5 gcall_hit", gcall_hit, e[1]);
        scl_drv = 1'b1; wt(W);
        chk({tag, " ack pull during 9th high"}, sda_pull, ack);
        scl_drv = 1'b0; wt(W);
        chk("R6 irq pulses", irq_cnt - irq0, ack);
        chk("R6 pend after 9th fall", pend, !ack);
        chk("R7 scl held", scl_pull, ack);
        chk("R4 sda released after 9th", sda_pull, 0);
        if (ack) exp_trx = b[0];
        chk("R8 trx", trx, exp_trx);
        if (ack) begin
            pend_set = 1'b1; @(negedge clk); pend_set = 1'b0;
            wt(2);
            chk("R7 released by host", scl_pull, 0);
            chk("R7 pend set", pend, 1);
        end else begin
            irq0 = irq_cnt;
            bits8({own, 1'b0});
            chk("R9 no pull on later bits", sda_pull, 0);
            scl_drv = 1'b1; wt(W);
            chk("R9 no ack on 9th", sda_pull, 0);
            scl_drv = 1'b0; wt(W);
            chk("R9 no irq", irq_cnt - irq0, 0);
            chk("R9 no scl hold", scl_pull, 0);
        end
        stop_c();
        chk("R2 busy cleared at stop", busy, 0);
    endtask

    initial begin
        wt(3);
        chk("R1 pend", pend, 1);
        chk("R1 trx", trx, 0);
        chk("R1 busy", busy, 0);
        chk("R1 hits", {gcall_hit, addr_hit}, 0);
        chk("R1 pulls", {sda_pull, scl_pull}, 0);
        rst_n = 1'b1;
        wt(4);
        chk("R1 idle after release", {sda_pull, scl_pull, busy}, 0);

        // R3: order check, own 0x5A read, and its bit reverse
        xact(8'hB5, "R3 msb-first match");
        xact(8'hAD, "R3 reversed byte");
        xact(8'hB4, "R4 own write");
        xact(8'h00, "R5 general call");
        fmt = 1'b1;
        xact(8'h00, "R10 fmt blocks gcall");
        xact(8'hB5, "R10 fmt blocks own");
        fmt = 1'b0;

        // R11: start in the middle of the address
        start_c();
        clk_bit(1'b0); clk_bit(1'b1); clk_bit(1'b1);
        xact(8'hB5, "R11 restart");

        void'($urandom(32'hC0FFEE));
        for (int n = 0; n < 30; n++) begin
            logic [7:0] b;
            int sel;
            own = 7'($urandom_range(0, 127));
            fmt = ($urandom_range(0, 5) == 0);
            sel = $urandom_range(0, 3);
            case (sel)
                0: b = {own, 1'($urandom_range(0, 1))};
                1: b = 8'h00;
                2: b = 8'($urandom_range(0, 255));
                default: b = 8'h01;
            endcase
            xact(b, "R4 random");
        end
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule